// File: doc/BRIEF.md
# Compact Double Table-Lookup Codec

This block converts between 64-bit IEEE binary64 values and a 32-bit compact code. The compact code is the upper word of the double, bits 63..32: sign, the whole 11-bit exponent and the top 20 mantissa bits. The lower word is not stored. It is rebuilt from a small lookup table that holds one 32-bit low-mantissa word for each index. The index is built from a few low mantissa bits of the upper word together with a short slice of the exponent field. This lets a data set made of decimal-like values keep half the storage and still be rebuilt bit for bit.

The block has two independent pipelined channels that share one table. The decode channel takes a compact code and returns the full 64-bit value one cycle later. The encode channel takes a full double and copies out its upper word. It also reads the table with that word's index and compares the word it gets back with the input's lower word. The result is presented two cycles later, with a flag that is raised when the round trip would not give back the same value. Software, or a neighbouring block, fills the table before use through a synchronous write port. Every channel edge uses a valid/ready handshake.

Top module: `cdc_top`

## Requirements
- R1: After reset, both output valids are low and both input readys are high.
- R2: When the write enable is high at a clock edge, the table entry at the write address takes the 32-bit write data. A later write to the same address replaces the entry.
- R3: The table index of an upper word `u` is `{u[20+EXP_OFS +: EXP_BITS], u[MAN_BITS-1:0]}`. The exponent slice forms the high part of the index and the low mantissa bits form the low part.
- R4: A decode input accepted at one clock edge is presented at the next edge as `{code, table[index(code)]}` with decode output valid high.
- R5: An encode input accepted at one clock edge is presented two edges later, if no stall occurs, with the encode output code equal to bits 63..32 of the input.
- R6: The encode not-exact flag is high exactly when `table[index(value[63:32])]` differs from `value[31:0]`. It is valid together with the code.
- R7: While decode output valid is high and the output ready is low, the decode output value holds steady and the decode input ready is low.
- R8: While encode output valid is high and the output ready is low, the encode code and flag hold steady and the encode input ready is low.
- R9: With the output ready held high, each channel accepts one item per cycle and delivers results in order with no gaps.
- R10: The two channels run at the same time without affecting each other's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | MAN_BITS+EXP_BITS | Table write address |
| tbl_wdata | input | 32 | Table write data (low mantissa word) |
| dec_in_valid | input | 1 | Decode input valid |
| dec_in_ready | output | 1 | Decode input ready |
| dec_in_code | input | 32 | Compact code to decode |
| dec_out_valid | output | 1 | Decode output valid |
| dec_out_ready | input | 1 | Decode output ready |
| dec_out_value | output | 64 | Rebuilt binary64 value |
| enc_in_valid | input | 1 | Encode input valid |
| enc_in_ready | output | 1 | Encode input ready |
| enc_in_value | input | 64 | binary64 value to encode |
| enc_out_valid | output | 1 | Encode output valid |
| enc_out_ready | input | 1 | Encode output ready |
| enc_out_code | output | 32 | Compact code (upper word) |
| enc_out_inexact | output | 1 | High when the code does not rebuild the input |

## Verification
The bench uses codes whose index is all zeros and all ones, so a swapped or shifted index field reads the wrong entry and gives a wrong low word. For each vector it flips the lowest mantissa bit of an encodable value. A flag that is inverted, stuck, or compared against the wrong word then fails in one direction or the other. It also holds the output ready low while a second item waits. A pipeline that drops, repeats or overwrites an item under backpressure shows up as a changed output or a lost item. Back-to-back streams on both channels at once catch a read register that is not lined up with its stage.

// File: rtl/cdc_pkg.sv
package cdc_pkg;

    localparam int unsigned UPPER_W = 32;
    localparam int unsigned DBL_W   = 64;
    localparam int unsigned EXP_LSB = 20;

    typedef struct packed {
        logic               valid;
        logic [UPPER_W-1:0] code;
    } dec_stage_t;

    typedef struct packed {
        logic             valid;
        logic [DBL_W-1:0] value;
    } enc_s1_t;

    typedef struct packed {
        logic               valid;
        logic [UPPER_W-1:0] code;
        logic               inexact;
    } enc_s2_t;

endpackage

// File: rtl/cdc_table.sv
module cdc_table #(
    parameter int unsigned IDX_W  = 9,
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              a_en,
    input  logic [IDX_W-1:0]  a_addr,
    output logic [WORD_W-1:0] a_data,
    input  logic              b_en,
    input  logic [IDX_W-1:0]  b_addr,
    output logic [WORD_W-1:0] b_data
);
    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
        if (a_en) begin
            a_data <= mem_q[a_addr];
        end
        if (b_en) begin
            b_data <= mem_q[b_addr];
        end
    end

endmodule

// File: rtl/cdc_decoder.sv
module cdc_decoder
    import cdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [UPPER_W-1:0] in_code,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DBL_W-1:0]   out_value,
    output logic               rd_en,
    input  logic [UPPER_W-1:0] rd_data
);
    dec_stage_t st_d, st_q;
    logic       adv;

    always_comb begin
        st_d = st_q;
        adv  = !st_q.valid || out_ready;
        if (adv) begin
            st_d.valid = in_valid;
            st_d.code  = in_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = adv;
    assign rd_en     = adv;
    assign out_valid = st_q.valid;
    assign out_value = {st_q.code, rd_data};

    AST_DEC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R4

    AST_DEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_value))); // R7

endmodule

// File: rtl/cdc_encoder.sv
module cdc_encoder
    import cdc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [DBL_W-1:0]   in_value,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [UPPER_W-1:0] out_code,
    output logic               out_inexact,
    output logic               rd_en,
    input  logic [UPPER_W-1:0] rd_data
);
    enc_s1_t s1_d, s1_q;
    enc_s2_t s2_d, s2_q;
    logic    adv;

    always_comb begin
        s1_d = s1_q;
        s2_d = s2_q;
        adv  = !s2_q.valid || out_ready;
        if (adv) begin
            s2_d.valid   = s1_q.valid;
            s2_d.code    = s1_q.value[DBL_W-1:UPPER_W];
            s2_d.inexact = s1_q.valid && (rd_data != s1_q.value[UPPER_W-1:0]);
            s1_d.valid   = in_valid;
            s1_d.value   = in_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign in_ready    = adv;
    assign rd_en       = adv;
    assign out_valid   = s2_q.valid;
    assign out_code    = s2_q.code;
    assign out_inexact = s2_q.inexact;

    AST_ENC_CODE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && out_ready) |=> (out_valid && out_code == $past(s1_q.value[DBL_W-1:UPPER_W]))); // R5

    AST_ENC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_inexact))); // R8

    AST_ENC_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && s1_q.valid) |=> $stable(s1_q.value)); // R8

endmodule

// File: rtl/cdc_top.sv
module cdc_top
    import cdc_pkg::*;
#(
    parameter int unsigned MAN_BITS = 6,
    parameter int unsigned EXP_BITS = 3,
    parameter int unsigned EXP_OFS  = 0,
    localparam int unsigned IDX_W   = MAN_BITS + EXP_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_waddr,
    input  logic [UPPER_W-1:0] tbl_wdata,
    input  logic               dec_in_valid,
    output logic               dec_in_ready,
    input  logic [UPPER_W-1:0] dec_in_code,
    output logic               dec_out_valid,
    input  logic               dec_out_ready,
    output logic [DBL_W-1:0]   dec_out_value,
    input  logic               enc_in_valid,
    output logic               enc_in_ready,
    input  logic [DBL_W-1:0]   enc_in_value,
    output logic               enc_out_valid,
    input  logic               enc_out_ready,
    output logic [UPPER_W-1:0] enc_out_code,
    output logic               enc_out_inexact
);
    localparam int unsigned SLICE_LSB = EXP_LSB + EXP_OFS;

    logic [IDX_W-1:0]   dec_idx, enc_idx;
    logic               dec_rd_en, enc_rd_en;
    logic [UPPER_W-1:0] dec_rd_data, enc_rd_data;

    assign dec_idx = {dec_in_code[SLICE_LSB +: EXP_BITS], dec_in_code[MAN_BITS-1:0]};
    assign enc_idx = {enc_in_value[UPPER_W + SLICE_LSB +: EXP_BITS],
                      enc_in_value[UPPER_W +: MAN_BITS]};

    cdc_table #(.IDX_W(IDX_W), .WORD_W(UPPER_W)) i_table (
        .clk    (clk),
        .we     (tbl_we),
        .waddr  (tbl_waddr),
        .wdata  (tbl_wdata),
        .a_en   (dec_rd_en),
        .a_addr (dec_idx),
        .a_data (dec_rd_data),
        .b_en   (enc_rd_en),
        .b_addr (enc_idx),
        .b_data (enc_rd_data)
    );

    cdc_decoder i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_code   (dec_in_code),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_value (dec_out_value),
        .rd_en     (dec_rd_en),
        .rd_data   (dec_rd_data)
    );

    cdc_encoder i_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (enc_in_valid),
        .in_ready    (enc_in_ready),
        .in_value    (enc_in_value),
        .out_valid   (enc_out_valid),
        .out_ready   (enc_out_ready),
        .out_code    (enc_out_code),
        .out_inexact (enc_out_inexact),
        .rd_en       (enc_rd_en),
        .rd_data     (enc_rd_data)
    );

    AST_DEC_UPPER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_in_valid && dec_in_ready) |=> (dec_out_value[DBL_W-1:UPPER_W] == $past(dec_in_code))); // R4

endmodule

// File: tb/test_cdc_top.sv
module test_cdc_top;
    localparam int unsigned M     = 6;
    localparam int unsigned E     = 3;
    localparam int unsigned F     = 0;
    localparam int unsigned IW    = M + E;
    localparam int unsigned DEPTH = 1 << IW;
    localparam int unsigned NV    = 8;

    localparam logic [31:0] VEC [NV] = '{
        32'h4008_0000, 32'h4077_FFFF, 32'h3FF0_0015, 32'hC05E_DD2A,
        32'h3F84_7AE1, 32'h40C3_8803, 32'hBFB9_999A, 32'h4124_F83F
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_we = 1'b0;
    logic [IW-1:0] tbl_waddr = '0;
    logic [31:0] tbl_wdata = '0;
    logic        dec_in_valid = 1'b0;
    logic        dec_in_ready;
    logic [31:0] dec_in_code = '0;
    logic        dec_out_valid;
    logic        dec_out_ready = 1'b1;
    logic [63:0] dec_out_value;
    logic        enc_in_valid = 1'b0;
    logic        enc_in_ready;
    logic [63:0] enc_in_value = '0;
    logic        enc_out_valid;
    logic        enc_out_ready = 1'b1;
    logic [31:0] enc_out_code;
    logic        enc_out_inexact;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [DEPTH];

    always #2 clk = ~clk;

    cdc_top #(.MAN_BITS(M), .EXP_BITS(E), .EXP_OFS(F)) i_cdc_top (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_in_code(dec_in_code),
        .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready), .dec_out_value(dec_out_value),
        .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_in_value(enc_in_value),
        .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_out_code(enc_out_code),
        .enc_out_inexact(enc_out_inexact)
    );

    function automatic logic [IW-1:0] idx_of(logic [31:0] c);
        return {c[20+F +: E], c[M-1:0]};
    endfunction

    function automatic logic [31:0] gen_word(int i);
        return (32'h9E37_79B9 * i) ^ 32'h1234_5678 ^ (i << 11);
    endfunction

    function automatic logic [63:0] full_of(logic [31:0] c);
        return {c, model[idx_of(c)]};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic write_entry(int a, logic [31:0] w);
        @(negedge clk);
        tbl_we = 1'b1; tbl_waddr = IW'(a); tbl_wdata = w;
        model[a] = w;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic dec_one(logic [31:0] c, string req);
        @(negedge clk);
        dec_in_valid = 1'b1; dec_in_code = c;
        @(negedge clk);
        dec_in_valid = 1'b0;
        chk(req, {63'b0, dec_out_valid}, 64'd1);
        chk(req, dec_out_value, full_of(c));
    endtask

    task automatic enc_one(logic [63:0] v, logic exp_flag, string req);
        @(negedge clk);
        enc_in_valid = 1'b1; enc_in_value = v;
        @(negedge clk);
        enc_in_valid = 1'b0;
        @(negedge clk);
        chk(req, {63'b0, enc_out_valid}, 64'd1);
        chk(req, {32'b0, enc_out_code}, {32'b0, v[63:32]});
        chk(req, {63'b0, enc_out_inexact}, {63'b0, exp_flag});
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", {60'b0, dec_out_valid, enc_out_valid, dec_in_ready, enc_in_ready}, 64'b0011);

        // R2 load the whole table through the write port
        for (int a = 0; a < DEPTH; a++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_waddr = IW'(a); tbl_wdata = gen_word(a);
            model[a] = gen_word(a);
        end
        @(negedge clk);
        tbl_we = 1'b0;

        // vector walk: decode, exact encode, perturbed encode (R3 R4 R5 R6)
        for (int i = 0; i < NV; i++) begin
            dec_one(VEC[i], "R4/R3 decode");
            enc_one(full_of(VEC[i]), 1'b0, "R5/R6 exact");
            enc_one(full_of(VEC[i]) ^ 64'd1, 1'b1, "R6 perturbed");
        end

        // R3 index corners: index 0 and all ones read distinct entries
        chk("R3 idx0", {55'b0, idx_of(32'h4008_0000)}, 64'd0);
        chk("R3 idxmax", {55'b0, idx_of(32'h4077_FFFF)}, 64'(DEPTH - 1));

        // R2 overwrite an entry and observe it through decode
        write_entry(DEPTH - 1, 32'hDEAD_BEEF);
        dec_one(32'h4077_FFFF, "R2 overwrite");
        enc_one({32'h4077_FFFF, 32'hDEAD_BEEF}, 1'b0, "R2 overwrite enc");

        // R9 + R10 back-to-back streams on both channels together
        for (int i = 0; i <= NV + 1; i++) begin
            @(negedge clk);
            if (i >= 1 && i <= NV) chk("R9 dec stream", dec_out_value, full_of(VEC[i-1]));
            if (i >= 1 && i <= NV) chk("R9 dec valid", {63'b0, dec_out_valid}, 64'd1);
            if (i >= 2) begin
                chk("R10 enc stream", {32'b0, enc_out_code}, {32'b0, VEC[i-2]});
                chk("R10 enc flag", {63'b0, enc_out_inexact}, {63'b0, i[0]});
            end
            dec_in_valid = (i < NV);
            enc_in_valid = (i < NV);
            if (i < NV) begin
                dec_in_code  = VEC[i];
                enc_in_value = full_of(VEC[i]) ^ {63'b0, i[0]};
            end
        end
        @(negedge clk);

        // R7 decode backpressure
        dec_out_ready = 1'b0;
        dec_in_valid = 1'b1; dec_in_code = VEC[2];
        @(negedge clk);
        dec_in_code = VEC[5];
        for (int k = 0; k < 3; k++) begin
            chk("R7 hold", dec_out_value, full_of(VEC[2]));
            chk("R7 ready low", {63'b0, dec_in_ready}, 64'd0);
            @(negedge clk);
        end
        dec_out_ready = 1'b1;
        @(negedge clk);
        dec_in_valid = 1'b0;
        chk("R7 next item", dec_out_value, full_of(VEC[5]));

        // R8 encode backpressure
        enc_out_ready = 1'b0;
        enc_in_valid = 1'b1; enc_in_value = full_of(VEC[3]) ^ 64'h8;
        @(negedge clk);
        enc_in_value = full_of(VEC[6]);
        @(negedge clk);
        enc_in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R8 hold code", {32'b0, enc_out_code}, {32'b0, VEC[3]});
            chk("R8 hold flag", {63'b0, enc_out_inexact}, 64'd1);
            chk("R8 ready low", {63'b0, enc_in_ready}, 64'd0);
            @(negedge clk);
        end
        enc_out_ready = 1'b1;
        @(negedge clk);
        chk("R8 next code", {32'b0, enc_out_code}, {32'b0, VEC[6]});
        chk("R8 next flag", {63'b0, enc_out_inexact}, 64'd0);

        // R1 reset mid-run clears valids
        enc_in_valid = 1'b1; dec_in_valid = 1'b1;
        @(negedge clk);
        rst_n = 1'b0; enc_in_valid = 1'b0; dec_in_valid = 1'b0;
        @(negedge clk);
        chk("R1 reset again", {62'b0, dec_out_valid, enc_out_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule